// File: doc/BRIEF.md
# ADC Power and Sampling Sequencer

This block lives in the always-on domain and drives an external multi-channel analog-to-digital converter. It controls when the converter is powered, waits a programmed settling time after power-up, and then selects the channels one after another. For each selected channel it accepts one conversion result through a single-cycle valid strobe, and it reports each result on a per-channel sample-valid pulse.

There are two sampling schedules. In normal-power mode, rounds of conversions follow one another without a break and the converter stays powered. In low-power mode, the block runs one burst over all channels, cuts converter power for a programmed wakeup interval, powers up again and runs the next burst. An external filter reports, for each accepted conversion, whether the value lies in the range of interest. Enough consecutive matching bursts move the block from low power to normal power. Enough consecutive matching rounds in normal power raise an interrupt pulse and a wakeup request.

Software can return the whole sequencer (state, both timers, both streak counters and the outputs) to its starting point with a synchronous reset strobe. It can also stop it by dropping the enable.

Top module: `adc_pwr_seq`

## Requirements
- R1: At most one bit of `adc_sel_o` is high in any cycle, and no bit is ever unknown.
- R2: Each time `adc_pd_o` falls, exactly `pwrup_time_i`+1 cycles pass with power on and no select before the first select rises. No select is ever high while `adc_pd_o` is high.
- R3: Channels are selected in ascending order from 0 to NUM_CH-1 and then wrap to 0. After every power-up the order starts at channel 0. A select holds until a conversion is accepted. After that, all selects stay low for exactly one cycle before the next select, unless the converter powers down.
- R4: A conversion is accepted when `adc_valid_i` is high in a cycle with a select high. In the next cycle the `smp_valid_o` bit of that channel is high for one cycle and `smp_data_o` equals the accepted data. In every other cycle `smp_valid_o` is zero.
- R5: In low-power mode, a burst that does not trigger the mode switch is followed by one cycle with all selects low. Then `adc_pd_o` is high for exactly `wakeup_time_i`+1 cycles, and the power-up delay of R2 follows. Power drops without a reset or disable only in low-power mode.
- R6: The mode is taken from `lp_mode_i` (1 = low power) when the block leaves its stopped state. A burst matches when `match_i` was high for every conversion accepted in it. In low-power mode, consecutive matching bursts are counted and a non-matching burst clears the count. The burst that brings the count to `lp_target_i` keeps power on, and sampling continues at channel 0 in normal-power mode, whose count starts from zero.
- R7: In normal-power mode, `adc_pd_o` stays low. Consecutive matching rounds are counted and a non-matching round clears the count. In the cycle after the round that brings the count to `np_target_i` delivers its last `smp_valid_o` pulse, `irq_o` is high for one cycle and `wakeup_o` goes high. `wakeup_o` then stays high until a reset or disable. Further matching rounds raise no new pulse. Targets must be nonzero.
- R8: From the cycle after `fsm_rst_i` is high, and for as long as it stays high, `adc_pd_o` is high, all selects are low and `irq_o` and `wakeup_o` are low. Both timers and both streak counters are zero. After release, the full power-up delay applies and counting starts again from zero.
- R9: While `enable_i` is low, and after the asynchronous reset `rst_ni`, the block is in the same stopped state as in R8. Enabling it again starts from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Sampling enable |
| lp_mode_i | input | 1 | Starting mode: 1 low power, 0 normal power |
| fsm_rst_i | input | 1 | Synchronous software reset of the sequencer |
| pwrup_time_i | input | PWRUP_W | Settling cycles after power-up, minus one |
| wakeup_time_i | input | WAKE_W | Power-off cycles between bursts, minus one |
| np_target_i | input | NP_W | Matching rounds needed to raise the interrupt |
| lp_target_i | input | LP_W | Matching bursts needed to leave low power |
| adc_valid_i | input | 1 | Conversion result valid strobe |
| adc_data_i | input | DATA_W | Conversion result |
| match_i | input | 1 | Filter match for the current result |
| adc_pd_o | output | 1 | Converter power-down |
| adc_sel_o | output | NUM_CH | One-hot channel select |
| smp_valid_o | output | NUM_CH | Per-channel sample-valid pulse |
| smp_data_o | output | DATA_W | Last accepted sample |
| irq_o | output | 1 | Interrupt pulse |
| wakeup_o | output | 1 | Sticky wakeup request |

## Verification
A wrong state or a wrong channel index shows at the ports within one cycle. It appears as a select out of order, a select raised while powered down, or a gap between selects that is not one cycle long. A timer that counts from the wrong start or stops on the wrong limit changes the length of the power-up or power-off window. The bench measures that length to the cycle each time power changes. A streak counter that is not cleared by a mismatch, a reset or a disable does not show for several rounds. It then appears as an interrupt in the wrong round, or as no interrupt at all. So the bench counts rounds from each restart and compares the round in which `irq_o` fires against the programmed target.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PWRUP = 3'd1,
      ST_SEL   = 3'd2,
      ST_GAP   = 3'd3,
      ST_SLEEP = 3'd4
   } seq_state_e;

endpackage

// File: rtl/adc_seq_timer.sv
// Up-counter that reports when it has reached a programmed limit.
module adc_seq_timer #(
   parameter int W = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         done_o
);

   logic [W-1:0] cnt_q;

   assign done_o = run_i && (cnt_q == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (run_i)   cnt_q <= done_o ? '0 : cnt_q + 1'b1;
   end

   // R8: a clear leaves the timer at zero
   p_timer_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/adc_seq_streak.sv
// Counts consecutive matching rounds; SATURATE selects hold-at-target or restart.
module adc_seq_streak #(
   parameter int W        = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         round_i,
   input  logic         ok_i,
   input  logic [W-1:0] target_i,
   output logic         hit_o,
   output logic [W-1:0] count_o
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] after_hit;
   logic [W:0]   nxt;

   assign nxt     = {1'b0, cnt_q} + 1'b1;
   assign hit_o   = round_i && ok_i && (nxt == {1'b0, target_i});
   assign count_o = cnt_q;

   generate
      if (SATURATE) begin : g_hold
         assign after_hit = target_i;
      end else begin : g_restart
         assign after_hit = '0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (clr_i)             cnt_q <= '0;
      else if (round_i) begin
         if (!ok_i)               cnt_q <= '0;
         else if (hit_o)          cnt_q <= after_hit;
         else if (cnt_q < target_i) cnt_q <= cnt_q + 1'b1;
      end
   end

   // R8: clear empties the counter
   p_streak_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (count_o == '0));
   // R7: a non-matching round breaks the streak
   p_streak_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (round_i && !ok_i && !clr_i) |=> (count_o == '0));

endmodule

// File: rtl/adc_seq_chan.sv
// Channel select decode and per-channel sample capture.
module adc_seq_chan #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 10,
   parameter int CH_W   = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              active_i,
   input  logic [CH_W-1:0]   ch_idx_i,
   input  logic              accept_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [NUM_CH-1:0] sel_o,
   output logic [NUM_CH-1:0] smp_valid_o,
   output logic [DATA_W-1:0] smp_data_o
);

   logic [DATA_W-1:0] data_q;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic vld_q;
         assign sel_o[i] = active_i && (ch_idx_i == CH_W'(i));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) vld_q <= 1'b0;
            else         vld_q <= !clr_i && accept_i && (ch_idx_i == CH_W'(i));
         end
         assign smp_valid_o[i] = vld_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       data_q <= '0;
      else if (accept_i) data_q <= data_i;
   end
   assign smp_data_o = data_q;

   // R1: select never has two bits set and never goes unknown
   p_sel_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$isunknown(sel_o) && $onehot0(sel_o));
   // R4: an accepted conversion is reported on the channel that was selected
   p_smp_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_i && !clr_i) |=> (smp_valid_o == $past(sel_o)));

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter int DATA_W  = 10,
   parameter int PWRUP_W = 4,
   parameter int WAKE_W  = 8,
   parameter int NP_W    = 4,
   parameter int LP_W    = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               enable_i,
   input  logic               lp_mode_i,
   input  logic               fsm_rst_i,
   input  logic [PWRUP_W-1:0] pwrup_time_i,
   input  logic [WAKE_W-1:0]  wakeup_time_i,
   input  logic [NP_W-1:0]    np_target_i,
   input  logic [LP_W-1:0]    lp_target_i,
   input  logic               adc_valid_i,
   input  logic [DATA_W-1:0]  adc_data_i,
   input  logic               match_i,
   output logic               adc_pd_o,
   output logic [NUM_CH-1:0]  adc_sel_o,
   output logic [NUM_CH-1:0]  smp_valid_o,
   output logic [DATA_W-1:0]  smp_data_o,
   output logic               irq_o,
   output logic               wakeup_o
);

   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   generate
      if (NUM_CH < 2)  begin : g_bad_ch   $error("NUM_CH must be at least 2");  end
      if (DATA_W < 1)  begin : g_bad_data $error("DATA_W must be positive");    end
      if (PWRUP_W < 1 || WAKE_W < 1 || NP_W < 1 || LP_W < 1) begin : g_bad_w
         $error("timer and counter widths must be positive");
      end
   endgenerate

   seq_state_e      state_q, state_d;
   logic [CH_W-1:0] ch_q;
   logic            lp_act_q, round_ok_q, irq_q, wake_q;
   logic            clr, in_sel, accept, last_ch, round_end;
   logic            pw_done, wk_done, np_hit, lp_hit;
   logic [NP_W-1:0] np_cnt;
   logic [LP_W-1:0] lp_cnt;

   assign clr       = fsm_rst_i | ~enable_i;
   assign in_sel    = (state_q == ST_SEL);
   assign accept    = in_sel && adc_valid_i;
   assign last_ch   = (ch_q == LAST_CH);
   assign round_end = (state_q == ST_GAP) && last_ch;

   adc_seq_timer #(.W(PWRUP_W)) u_pwrup_tmr (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .run_i(state_q == ST_PWRUP), .limit_i(pwrup_time_i), .done_o(pw_done));

   adc_seq_timer #(.W(WAKE_W)) u_wake_tmr (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .run_i(state_q == ST_SLEEP), .limit_i(wakeup_time_i), .done_o(wk_done));

   adc_seq_streak #(.W(NP_W), .SATURATE(1'b1)) u_np_streak (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .round_i(round_end && !lp_act_q), .ok_i(round_ok_q),
      .target_i(np_target_i), .hit_o(np_hit), .count_o(np_cnt));

   adc_seq_streak #(.W(LP_W), .SATURATE(1'b0)) u_lp_streak (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .round_i(round_end && lp_act_q), .ok_i(round_ok_q),
      .target_i(lp_target_i), .hit_o(lp_hit), .count_o(lp_cnt));

   adc_seq_chan #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .active_i(in_sel), .ch_idx_i(ch_q), .accept_i(accept),
      .data_i(adc_data_i), .sel_o(adc_sel_o),
      .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  state_d = ST_PWRUP;
         ST_PWRUP: if (pw_done) state_d = ST_SEL;
         ST_SEL:   if (adc_valid_i) state_d = ST_GAP;
         ST_GAP: begin
            if (last_ch && lp_act_q && !lp_hit) state_d = ST_SLEEP;
            else                                state_d = ST_SEL;
         end
         ST_SLEEP: if (wk_done) state_d = ST_PWRUP;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         ch_q       <= '0;
         lp_act_q   <= 1'b0;
         round_ok_q <= 1'b1;
         irq_q      <= 1'b0;
         wake_q     <= 1'b0;
      end else if (clr) begin
         state_q    <= ST_IDLE;
         ch_q       <= '0;
         lp_act_q   <= lp_mode_i;
         round_ok_q <= 1'b1;
         irq_q      <= 1'b0;
         wake_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE) lp_act_q <= lp_mode_i;
         else if (lp_hit)        lp_act_q <= 1'b0;
         if (state_q == ST_GAP)  ch_q <= last_ch ? '0 : ch_q + 1'b1;
         if (accept)             round_ok_q <= round_ok_q & match_i;
         else if (round_end)     round_ok_q <= 1'b1;
         irq_q <= np_hit;
         if (np_hit) wake_q <= 1'b1;
      end
   end

   assign adc_pd_o = (state_q == ST_IDLE) || (state_q == ST_SLEEP);
   assign irq_o    = irq_q;
   assign wakeup_o = wake_q;

   // R2: a select is only raised while the converter is powered
   p_sel_powered_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|adc_sel_o) |-> !adc_pd_o);
   // R3: accepting a conversion drops every select for the next cycle
   p_gap_after_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && !clr) |=> (adc_sel_o == '0));
   // R5: power drops without a control cause only in low-power mode
   p_pd_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(adc_pd_o) && $past(enable_i) && !$past(fsm_rst_i)) |-> $past(lp_act_q));
   // R7: interrupt is a single-cycle pulse
   p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);
   // R7: wakeup request holds until a reset or disable
   p_wake_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wakeup_o && enable_i && !fsm_rst_i) |=> wakeup_o);
   // R8: software reset forces the stopped state and empties both streaks
   p_fsm_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fsm_rst_i |=> (adc_pd_o && adc_sel_o == '0 && !irq_o && !wakeup_o
                     && np_cnt == '0 && lp_cnt == '0));
   // R9: disable forces the stopped state
   p_disable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (adc_pd_o && adc_sel_o == '0 && !irq_o && !wakeup_o));

endmodule

// File: tb/tb_adc_pwr_seq.sv
module tb_adc_pwr_seq;

   localparam int CLK_T = 10;
   localparam int N     = 3;
   localparam int DW    = 10;

   logic clk = 1'b0;
   always #(CLK_T/2) clk = ~clk;

   logic          rst_n = 1'b0;
   logic          enable = 1'b0, lp_mode = 1'b0, fsm_rst = 1'b0;
   logic [3:0]    pwrup_time = '0;
   logic [7:0]    wakeup_time = '0;
   logic [3:0]    np_target = 4'd1, lp_target = 4'd1;
   logic          adc_valid = 1'b0, match = 1'b1;
   logic [DW-1:0] adc_data = '0;
   logic          pd, irq, wake;
   logic [N-1:0]  sel, sv;
   logic [DW-1:0] sdata;

   adc_pwr_seq #(.NUM_CH(N), .DATA_W(DW), .PWRUP_W(4), .WAKE_W(8), .NP_W(4), .LP_W(4)) dut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .lp_mode_i(lp_mode),
      .fsm_rst_i(fsm_rst), .pwrup_time_i(pwrup_time), .wakeup_time_i(wakeup_time),
      .np_target_i(np_target), .lp_target_i(lp_target), .adc_valid_i(adc_valid),
      .adc_data_i(adc_data), .match_i(match), .adc_pd_o(pd), .adc_sel_o(sel),
      .smp_valid_o(sv), .smp_data_o(sdata), .irq_o(irq), .wakeup_o(wake));

   int checks = 0, errors = 0;
   int run_id = 0, mism = -1;

   // monitor state, written only by the negedge process
   int seen_run = 0, rounds = 0, conv = 0, pd_rises = 0, irq_cnt = 0, irq_round = -1;
   int pwr_len = 0, gap_len = 0, pd_len = 0, next_ch = 0;
   bit pend = 0, seen_sel = 0, pd_burst = 0, pd_prev = 1, prev_ctrl = 1;
   logic [N-1:0]  sel_prev = '0;
   int            pend_ch = 0;
   logic [DW-1:0] pend_data = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sel_idx(input logic [N-1:0] s);
      int r = 0;
      for (int i = 0; i < N; i++) if (s[i]) r = i;
      return r;
   endfunction

   // ADC model and port monitor, all at the falling edge
   always @(negedge clk) begin
      bit ctrl_now;
      ctrl_now = fsm_rst || !enable;
      if (run_id != seen_run) begin
         seen_run = run_id; rounds = 0; conv = 0; pd_rises = 0; irq_cnt = 0; irq_round = -1;
      end
      if (rst_n) begin
         chk(!$isunknown(sel) && $countones(sel) <= 1, "R1 select one-hot", int'(sel), 0);
         if (pend) begin
            chk(sv == N'(1 << pend_ch), "R4 sample valid channel", int'(sv), 1 << pend_ch);
            chk(sdata == pend_data, "R4 sample data", int'(sdata), int'(pend_data));
         end else begin
            chk(sv == '0, "R4 no stray sample valid", int'(sv), 0);
         end
         if (sv[N-1]) rounds++;
         if (irq) begin irq_cnt++; irq_round = rounds; end
         if (pd) begin
            chk(sel == '0, "R2 no select while powered down", int'(sel), 0);
            next_ch = 0; seen_sel = 0; pwr_len = 0; gap_len = 0;
            if (!pd_prev) begin
               pd_len = 1; pd_burst = !prev_ctrl;
               if (pd_burst) pd_rises++;
            end else begin
               pd_len++;
               if (prev_ctrl) pd_burst = 0;
            end
         end else begin
            if (pd_prev && pd_burst)
               chk(pd_len == int'(wakeup_time) + 1, "R5 power-off window", pd_len, int'(wakeup_time) + 1);
            if (pd_prev) pd_burst = 0;
            if (sel == '0) begin
               if (seen_sel) gap_len++; else pwr_len++;
            end else if (sel_prev == '0) begin
               chk(sel_idx(sel) == next_ch, "R3 channel order", sel_idx(sel), next_ch);
               if (seen_sel) chk(gap_len == 1, "R3 one-cycle gap", gap_len, 1);
               else chk(pwr_len == int'(pwrup_time) + 1, "R2 power-up delay", pwr_len, int'(pwrup_time) + 1);
               next_ch = (sel_idx(sel) + 1) % N;
               seen_sel = 1; gap_len = 0;
            end
         end
         // responder
         pend = 0;
         if (adc_valid) adc_valid = 1'b0;
         else if (sel != '0 && !ctrl_now) begin
            adc_valid = 1'b1;
            adc_data  = DW'(conv * 37 + 5);
            match     = (conv != mism);
            pend = 1; pend_ch = sel_idx(sel); pend_data = adc_data;
            conv++;
         end
         pd_prev = pd; sel_prev = sel; prev_ctrl = ctrl_now;
      end
   end

   task automatic step();
      @(posedge clk); #(CLK_T/4);
   endtask

   task automatic start_run(input bit lp, input int pt, input int wt, input int npc,
                            input int lpc, input int mm);
      step();
      fsm_rst = 1'b1; enable = 1'b1; lp_mode = lp;
      pwrup_time = 4'(pt); wakeup_time = 8'(wt);
      np_target = 4'(npc); lp_target = 4'(lpc); mism = mm;
      run_id++;
      step();
      fsm_rst = 1'b0;
   endtask

   task automatic wait_rounds(input int k);
      int g = 0;
      while (rounds < k && g < 4000) begin @(negedge clk); g++; end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: stopped state after reset with enable low
      chk(pd == 1'b1, "R9 reset power-down", int'(pd), 1);
      chk(sel == '0, "R9 reset selects", int'(sel), 0);
      chk(sv == '0 && irq == 1'b0, "R9 reset valid/irq", int'(sv) + int'(irq), 0);
      chk(wake == 1'b0, "R9 reset wakeup", int'(wake), 0);

      // R7: normal power sweep
      for (int pt = 0; pt < 4; pt += 1) begin
         for (int npc = 1; npc <= 3; npc++) begin
            start_run(1'b0, pt, 3, npc, 1, -1);
            wait_rounds(npc + 3);
            chk(irq_cnt == 1, "R7 single irq pulse", irq_cnt, 1);
            chk(irq_round == npc, "R7 irq round", irq_round, npc);
            chk(wake == 1'b1, "R7 wakeup held", int'(wake), 1);
            chk(pd_rises == 0, "R7 never powers down", pd_rises, 0);
         end
      end

      // R7: a mismatching round clears the streak
      for (int mr = 1; mr <= 2; mr++) begin
         start_run(1'b0, 1, 3, 3, 1, (mr - 1) * N + 1);
         wait_rounds(mr + 4);
         chk(irq_round == mr + 3, "R7 mismatch restarts count", irq_round, mr + 3);
      end

      // R5 R6: low power sweep
      for (int wt = 0; wt <= 6; wt += 3) begin
         for (int lpc = 1; lpc <= 3; lpc++) begin
            start_run(1'b1, 1, wt, 2, lpc, -1);
            wait_rounds(lpc + 4);
            chk(pd_rises == lpc - 1, "R6 bursts before switch", pd_rises, lpc - 1);
            chk(irq_round == lpc + 2, "R6 normal count after switch", irq_round, lpc + 2);
         end
      end

      // R6: mismatching burst clears the low-power streak
      start_run(1'b1, 2, 4, 2, 2, N + 1);
      wait_rounds(8);
      chk(pd_rises == 3, "R6 mismatch burst count", pd_rises, 3);
      chk(irq_round == 6, "R6 irq after late switch", irq_round, 6);

      // R8: software reset mid-run clears wakeup and counters
      begin
         int r0;
         start_run(1'b0, 2, 3, 3, 1, -1);
         wait_rounds(4);
         chk(wake == 1'b1, "R8 wakeup before reset", int'(wake), 1);
         step(); fsm_rst = 1'b1;
         step(); @(negedge clk);
         chk(pd == 1'b1 && sel == '0, "R8 stopped after strobe", int'(pd), 1);
         chk(wake == 1'b0, "R8 wakeup cleared", int'(wake), 0);
         step(); step(); @(negedge clk);
         chk(pd == 1'b1 && sel == '0, "R8 held while strobe high", int'(pd), 1);
         step(); fsm_rst = 1'b0;
         r0 = rounds;
         wait_rounds(r0 + 4);
         chk(irq_cnt == 2, "R8 irq again after reset", irq_cnt, 2);
         chk(irq_round == r0 + 3, "R8 streak counts from zero", irq_round - r0, 3);
      end

      // R9: disable mid-run behaves like the reset strobe
      begin
         int r0;
         start_run(1'b0, 1, 3, 3, 1, -1);
         wait_rounds(4);
         step(); enable = 1'b0;
         step(); @(negedge clk);
         chk(pd == 1'b1 && sel == '0, "R9 stopped when disabled", int'(pd), 1);
         chk(wake == 1'b0, "R9 wakeup cleared", int'(wake), 0);
         step(); enable = 1'b1;
         r0 = rounds;
         wait_rounds(r0 + 4);
         chk(irq_round == r0 + 3, "R9 restart counts from zero", irq_round - r0, 3);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule